// File: doc/BRIEF.md
# DRAM DLL mode switch sequencer

This block sits inside a DDR3-style memory controller and walks the attached DRAM from DLL-on to DLL-off operation, or back, with a clock frequency change in the middle. The controller hands it a quiet device: every bank is precharged, all timings are met and termination is off. A single start pulse, with a direction bit, then runs a fixed command script. The script is made of mode register writes, self refresh entry and exit, a retune request to the external clock generator, and, when the DLL is being turned on, a DLL reset followed by a long ZQ calibration.

Each step is followed by a programmable wait in clock cycles, and the sequencer drives NOP on every waiting cycle. While the device is in self refresh, the sequencer raises a retune request and holds until the clock generator reports a stable clock. That clock must then stay stable for the full exit window before self refresh is left. The block raises `busy_o` for the whole run and pulses `done_o` once, at the point where the device may take normal traffic again. When the DLL is being turned on, that point also respects the DLL lock time counted from the DLL reset write.

Top module: `dll_mode_seq`

## Requirements
- R1: After reset the block is idle: `cmd_o` = NOP, `cke_o` = 1, `busy_o` = 0, `done_o` = 0, `freq_req_o` = 0. A start is accepted only while idle with `odt_req_i` low. A start pulse raised while `odt_req_i` is high leaves `busy_o` low and issues no command. Command codes: NOP=0, MRS=1, SRE=2, SRX=3, ZQCL=4.
- R2: Disable run (`dll_on_i`=0): the first MRS comes one cycle after the start cycle, then SRE T_MOD later, SRX, MRS to MR2 T_XS after SRX, MRS to MR3 T_MRD later, and MRS to MR0 T_MRD after that.
- R3: The MRS to MR1 carries the register number 1 on `mr_sel_o`. Its data is MR1_VAL with bit 0 set on a disable run and with bit 0 cleared on an enable run. Every MRS puts its register number 0..3 on `mr_sel_o`.
- R4: Enable run (`dll_on_i`=1): SRE comes one cycle after the start cycle, then SRX, MRS to MR1 T_XS after SRX, MRS to MR0 T_MRD later, MRS to MR2 T_MOD later, MRS to MR3 T_MRD later, and ZQCL T_MOD after that.
- R5: MR0 data is MR0_VAL with bit 8 set on an enable run (DLL reset) and with bit 8 cleared on a disable run.
- R6: `cke_o` falls in the SRE cycle and rises in the SRX cycle. It is low for exactly SRX minus SRE cycles.
- R7: `freq_req_o` rises T_CKSRE cycles after SRE and stays high until a stable clock is seen. `freq_target_o` equals the latched direction.
- R8: SRX issues T_CKSRX cycles after the cycle in which `clk_stable_i` is first seen high in the request state. If `clk_stable_i` drops during that window, including its last cycle, SRX is withheld, `freq_req_o` returns high and the window restarts.
- R9: `done_o` is a single-cycle pulse. On a disable run it comes T_MOD after the MR0 write. On an enable run it comes max(T_ZQINIT, T_DLLK − 2·T_MOD − T_MRD) after ZQCL, which is never less than T_DLLK after the DLL reset write. The block is idle on the next cycle.
- R10: `odt_o` follows `odt_req_i` while idle and is forced low while busy.
- R11: Every cycle that is not a command cycle of the script drives NOP.
- R12: A start pulse while busy, including the `done_o` cycle, is ignored: the script, direction and timing are unchanged and no new run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a mode switch |
| dll_on_i | input | 1 | Direction: 1 = turn DLL on, 0 = turn DLL off |
| odt_req_i | input | 1 | Termination request from the controller |
| clk_stable_i | input | 1 | Clock generator reports a stable clock |
| busy_o | output | 1 | A switch is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a switch |
| freq_req_o | output | 1 | Ask the clock generator to retune |
| freq_target_o | output | 1 | Target operating point (latched direction) |
| cmd_o | output | 3 | DRAM command code |
| mr_sel_o | output | 2 | Mode register number for MRS |
| mr_data_o | output | 16 | Mode register data for MRS |
| cke_o | output | 1 | Clock enable to the DRAM |
| odt_o | output | 1 | Termination enable to the DRAM |

## Verification
The clock-stable handshake and the self refresh exit can land on the same cycle. This happens when the clock generator drops `clk_stable_i` on the last cycle of the exit window, which is exactly the cycle in which the timer would release SRX. The bench provokes this by lowering the input at that cycle. It then judges the result from the ports: the following cycle must show NOP, a raised retune request and CKE still low. After the clock is re-stabilised, SRX must appear a full T_CKSRX later. A start pulse placed on the `done_o` cycle is a second collision; it must start no new run.

// File: rtl/dms_pkg.sv
package dms_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_SRE  = 3'd2,
    CMD_SRX  = 3'd3,
    CMD_ZQCL = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_FREQ = 2'd1,
    K_END  = 2'd2
  } step_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FREQ  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  localparam int MRD_W  = 16;
  localparam int STEP_W = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dms_rst_sync.sv
module dms_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];
endmodule

// File: rtl/dms_down_timer.sv
module dms_down_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i || dec_i)  cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R11: a wait never counts below zero, so NOP spacing cannot wrap
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/dms_step_table.sv
module dms_step_table import dms_pkg::*; #(
  parameter int           CNT_W   = 10,
  parameter int           T_MOD   = 12,
  parameter int           T_MRD   = 4,
  parameter int           T_CKSRE = 10,
  parameter int           T_CKSRX = 10,
  parameter int           T_XS    = 120,
  parameter int           ZQ_WAIT = 512,
  parameter logic [15:0]  MR0_VAL = 16'h0B30,
  parameter logic [15:0]  MR1_VAL = 16'h0044,
  parameter logic [15:0]  MR2_VAL = 16'h0008,
  parameter logic [15:0]  MR3_VAL = 16'h0000
) (
  input  logic              dir_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_kind_e        kind_o,
  output cmd_e              cmd_o,
  output logic [1:0]        ba_o,
  output logic [MRD_W-1:0]  data_o,
  output logic [CNT_W-1:0]  wait_o,
  output step_kind_e        nxt_kind_o
);
  localparam logic [15:0] DLL_OFF_BIT = 16'h0001;
  localparam logic [15:0] DLL_RST_BIT = 16'h0100;

  function automatic step_kind_e kind_of(input logic dir, input logic [STEP_W-1:0] idx);
    if (dir) begin
      case (idx)
        4'd1:    return K_FREQ;
        4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return K_CMD;
        default: return K_END;
      endcase
    end else begin
      case (idx)
        4'd2:    return K_FREQ;
        4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6: return K_CMD;
        default: return K_END;
      endcase
    end
  endfunction

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'd0;
    data_o = '0;
    wait_o = '0;
    if (dir_i) begin
      case (idx_i)
        4'd0: begin cmd_o = CMD_SRE;  wait_o = CNT_W'(T_CKSRE); end
        4'd1: begin                   wait_o = CNT_W'(T_CKSRX); end
        4'd2: begin cmd_o = CMD_SRX;  wait_o = CNT_W'(T_XS);    end
        4'd3: begin cmd_o = CMD_MRS;  ba_o = 2'd1; data_o = MR1_VAL & ~DLL_OFF_BIT; wait_o = CNT_W'(T_MRD); end
        4'd4: begin cmd_o = CMD_MRS;  ba_o = 2'd0; data_o = MR0_VAL | DLL_RST_BIT;  wait_o = CNT_W'(T_MOD); end
        4'd5: begin cmd_o = CMD_MRS;  ba_o = 2'd2; data_o = MR2_VAL; wait_o = CNT_W'(T_MRD); end
        4'd6: begin cmd_o = CMD_MRS;  ba_o = 2'd3; data_o = MR3_VAL; wait_o = CNT_W'(T_MOD); end
        4'd7: begin cmd_o = CMD_ZQCL; wait_o = CNT_W'(ZQ_WAIT); end
        default: ;
      endcase
    end else begin
      case (idx_i)
        4'd0: begin cmd_o = CMD_MRS;  ba_o = 2'd1; data_o = MR1_VAL | DLL_OFF_BIT; wait_o = CNT_W'(T_MOD); end
        4'd1: begin cmd_o = CMD_SRE;  wait_o = CNT_W'(T_CKSRE); end
        4'd2: begin                   wait_o = CNT_W'(T_CKSRX); end
        4'd3: begin cmd_o = CMD_SRX;  wait_o = CNT_W'(T_XS);    end
        4'd4: begin cmd_o = CMD_MRS;  ba_o = 2'd2; data_o = MR2_VAL; wait_o = CNT_W'(T_MRD); end
        4'd5: begin cmd_o = CMD_MRS;  ba_o = 2'd3; data_o = MR3_VAL; wait_o = CNT_W'(T_MRD); end
        4'd6: begin cmd_o = CMD_MRS;  ba_o = 2'd0; data_o = MR0_VAL & ~DLL_RST_BIT; wait_o = CNT_W'(T_MOD); end
        default: ;
      endcase
    end
  end

  assign kind_o     = kind_of(dir_i, idx_i);
  assign nxt_kind_o = kind_of(dir_i, idx_i + 1'b1);
endmodule

// File: rtl/dll_mode_seq.sv
module dll_mode_seq import dms_pkg::*; #(
  parameter int          T_MOD    = 12,
  parameter int          T_MRD    = 4,
  parameter int          T_CKSRE  = 10,
  parameter int          T_CKSRX  = 10,
  parameter int          T_XS     = 120,
  parameter int          T_DLLK   = 512,
  parameter int          T_ZQINIT = 512,
  parameter logic [15:0] MR0_VAL  = 16'h0B30,
  parameter logic [15:0] MR1_VAL  = 16'h0044,
  parameter logic [15:0] MR2_VAL  = 16'h0008,
  parameter logic [15:0] MR3_VAL  = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        dll_on_i,
  input  logic        odt_req_i,
  input  logic        clk_stable_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        freq_req_o,
  output logic        freq_target_o,
  output logic [2:0]  cmd_o,
  output logic [1:0]  mr_sel_o,
  output logic [15:0] mr_data_o,
  output logic        cke_o,
  output logic        odt_o
);
  // cycles from DLL reset write to ZQCL issue: MR0 wait + MR2 wait + MR3 wait
  localparam int PRE_ZQ   = 2 * T_MOD + T_MRD;
  localparam int ZQ_WAIT  = imax(T_ZQINIT, T_DLLK - PRE_ZQ);
  localparam int MAX_WAIT = imax(imax(imax(T_MOD, T_MRD), imax(T_CKSRE, T_CKSRX)),
                                 imax(T_XS, ZQ_WAIT));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic srst_n;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              dir_q;
  logic              sr_q, sr_d;
  logic              accept;

  step_kind_e        cur_kind, nxt_kind;
  cmd_e              cur_cmd;
  logic [1:0]        cur_ba;
  logic [MRD_W-1:0]  cur_data;
  logic [CNT_W-1:0]  cur_wait;

  logic              tmr_load, tmr_dec, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic              issuing;

  dms_rst_sync u_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  dms_step_table #(
    .CNT_W   (CNT_W),
    .T_MOD   (T_MOD),
    .T_MRD   (T_MRD),
    .T_CKSRE (T_CKSRE),
    .T_CKSRX (T_CKSRX),
    .T_XS    (T_XS),
    .ZQ_WAIT (ZQ_WAIT),
    .MR0_VAL (MR0_VAL),
    .MR1_VAL (MR1_VAL),
    .MR2_VAL (MR2_VAL),
    .MR3_VAL (MR3_VAL)
  ) u_table (
    .dir_i      (dir_q),
    .idx_i      (step_q),
    .kind_o     (cur_kind),
    .cmd_o      (cur_cmd),
    .ba_o       (cur_ba),
    .data_o     (cur_data),
    .wait_o     (cur_wait),
    .nxt_kind_o (nxt_kind)
  );

  dms_down_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (srst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .last_o     (tmr_last)
  );

  assign accept  = (state_q == ST_IDLE) && start_i && !odt_req_i;
  assign issuing = (state_q == ST_ISSUE);
  assign tmr_val = cur_wait - 1'b1;

  // next-state process
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    sr_d     = sr_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ISSUE;
          step_d  = '0;
        end
      end
      ST_ISSUE: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
        if (cur_cmd == CMD_SRE) sr_d = 1'b1;
        if (cur_cmd == CMD_SRX) sr_d = 1'b0;
      end
      ST_WAIT: begin
        if ((cur_kind == K_FREQ) && !clk_stable_i) begin
          state_d = ST_FREQ;
        end else begin
          tmr_dec = 1'b1;
          if (tmr_last) begin
            step_d = step_q + 1'b1;
            unique case (nxt_kind)
              K_CMD:   state_d = ST_ISSUE;
              K_FREQ:  state_d = ST_FREQ;
              default: state_d = ST_DONE;
            endcase
          end
        end
      end
      ST_FREQ: begin
        if (clk_stable_i) begin
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      sr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      sr_q    <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     dir_q <= 1'b0;
    else if (accept) dir_q <= dll_on_i;
  end

  // outputs
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign freq_req_o    = (state_q == ST_FREQ);
  assign freq_target_o = dir_q;
  assign cmd_o         = issuing ? cur_cmd : CMD_NOP;
  assign mr_sel_o      = (issuing && cur_cmd == CMD_MRS) ? cur_ba : 2'd0;
  assign mr_data_o     = (issuing && cur_cmd == CMD_MRS) ? cur_data : '0;
  assign odt_o         = busy_o ? 1'b0 : odt_req_i;

  always_comb begin
    if (issuing && cur_cmd == CMD_SRE)      cke_o = 1'b0;
    else if (issuing && cur_cmd == CMD_SRX) cke_o = 1'b1;
    else                                    cke_o = !sr_q;
  end

  // R6: CKE edges only coincide with the self refresh commands
  a_r6_cke_fall_on_sre: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(cke_o) |-> (cmd_o == CMD_SRE));
  a_r6_cke_rise_on_srx: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cke_o) |-> (cmd_o == CMD_SRX));
  // R8: self refresh exit only follows a cycle with a stable clock
  a_r8_srx_after_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_o == CMD_SRX) |-> $past(clk_stable_i));
  // R7: retune is only requested while the device sits in self refresh
  a_r7_retune_in_sr: assert property (@(posedge clk) disable iff (!srst_n)
    freq_req_o |-> !cke_o);
  // R10: termination stays off whenever a command is driven
  a_r10_odt_off_on_cmd: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_o != CMD_NOP) |-> !odt_o);
  // R9: done is a single pulse that returns the block to idle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |=> (!done_o && !busy_o));
  // R12: the latched direction cannot change in the middle of a run
  a_r12_dir_held: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_o && $past(busy_o)) |-> $stable(freq_target_o));
endmodule

// File: tb/dll_mode_seq_tb.sv
`timescale 1ns/1ps
module dll_mode_seq_tb;
  localparam int T_MOD = 6, T_MRD = 4, T_CKSRE = 5, T_CKSRX = 7, T_XS = 9;
  localparam int T_DLLK = 60, T_ZQINIT = 20;
  localparam logic [15:0] MR0V = 16'h0B30, MR1V = 16'h0044, MR2V = 16'h0008, MR3V = 16'h0200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start_i, dll_on_i, odt_req_i, clk_stable_i;
  logic busy_o, done_o, freq_req_o, freq_target_o, cke_o, odt_o;
  logic [2:0]  cmd_o;
  logic [1:0]  mr_sel_o;
  logic [15:0] mr_data_o;

  dll_mode_seq #(
    .T_MOD(T_MOD), .T_MRD(T_MRD), .T_CKSRE(T_CKSRE), .T_CKSRX(T_CKSRX),
    .T_XS(T_XS), .T_DLLK(T_DLLK), .T_ZQINIT(T_ZQINIT),
    .MR0_VAL(MR0V), .MR1_VAL(MR1V), .MR2_VAL(MR2V), .MR3_VAL(MR3V)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dll_on_i(dll_on_i),
    .odt_req_i(odt_req_i), .clk_stable_i(clk_stable_i), .busy_o(busy_o),
    .done_o(done_o), .freq_req_o(freq_req_o), .freq_target_o(freq_target_o),
    .cmd_o(cmd_o), .mr_sel_o(mr_sel_o), .mr_data_o(mr_data_o),
    .cke_o(cke_o), .odt_o(odt_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  bit rec_en = 0;
  int n_ev, fr_cyc, done_cyc, n_done, low_cnt;
  bit fr_seen;
  int ev_cyc[16], ev_cmd[16], ev_ba[16], ev_dat[16], ev_cke[16];

  always @(posedge clk) cyc <= cyc + 1;

  // event recorder, samples between edges
  always @(negedge clk) begin
    if (rec_en) begin
      if (cmd_o != 3'd0 && n_ev < 16) begin
        ev_cyc[n_ev] = cyc; ev_cmd[n_ev] = int'(cmd_o); ev_ba[n_ev] = int'(mr_sel_o);
        ev_dat[n_ev] = int'(mr_data_o); ev_cke[n_ev] = int'(cke_o);
        n_ev++;
      end
      if (freq_req_o && !fr_seen) begin fr_seen = 1; fr_cyc = cyc; end
      if (done_o) begin n_done++; done_cyc = cyc; end
      if (!cke_o) low_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ev = 0; fr_cyc = 0; done_cyc = 0; n_done = 0; low_cnt = 0; fr_seen = 0;
    for (int i = 0; i < 16; i++) begin
      ev_cyc[i] = 0; ev_cmd[i] = 0; ev_ba[i] = 0; ev_dat[i] = 0; ev_cke[i] = 0;
    end
  endtask

  function automatic int zq_wait();
    int a = T_DLLK - 2 * T_MOD - T_MRD;
    return (T_ZQINIT > a) ? T_ZQINIT : a;
  endfunction

  // runs one switch; poke = mid-run start and ODT request, glitch = drop clock on last exit-window cycle
  task automatic run_seq(input bit en, input int dly, input bit glitch, input bit poke,
                         input bit hit_done, output int s, output int k);
    int g;
    @(negedge clk); start_i = 1; dll_on_i = en; s = cyc;
    @(negedge clk); start_i = 0;
    if (poke) begin
      @(negedge clk); start_i = 1; dll_on_i = !en; odt_req_i = 1;
      @(negedge clk); start_i = 0; dll_on_i = en;
      chk("R10 odt forced low while busy", int'(odt_o), 0);
      odt_req_i = 0;
    end
    g = 0;
    while (!freq_req_o && g < 500) begin @(negedge clk); g++; end
    chk("R7 freq_target equals direction", int'(freq_target_o), int'(en));
    clk_stable_i = 0;
    repeat (dly) @(negedge clk);
    clk_stable_i = 1; k = cyc;
    if (glitch) begin
      repeat (T_CKSRX - 1) @(negedge clk);
      clk_stable_i = 0;
      @(negedge clk);
      chk("R8 no SRX after late clock drop", int'(cmd_o == 3'd3), 0);
      chk("R8 retune re-requested", int'(freq_req_o), 1);
      chk("R6 cke still low", int'(cke_o), 0);
      repeat (2) @(negedge clk);
      clk_stable_i = 1; k = cyc;
    end
    g = 0;
    do begin @(negedge clk); g++; end while (!done_o && g < 2000);
    if (hit_done) start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic check_disable(input int s, input int k);
    chk("R2 disable event count", n_ev, 6);
    chk("R2 first MRS timing", ev_cyc[0], s + 1);
    chk("R3 MRS cmd", ev_cmd[0], 1);
    chk("R3 MR1 select", ev_ba[0], 1);
    chk("R3 MR1 dll off bit set", ev_dat[0], int'(MR1V | 16'h0001));
    chk("R2 SRE after tMOD", ev_cyc[1] - ev_cyc[0], T_MOD);
    chk("R2 SRE cmd", ev_cmd[1], 2);
    chk("R6 cke low at SRE", ev_cke[1], 0);
    chk("R7 retune after tCKSRE", fr_cyc - ev_cyc[1], T_CKSRE);
    chk("R8 SRX timing", ev_cyc[2], k + T_CKSRX);
    chk("R2 SRX cmd", ev_cmd[2], 3);
    chk("R6 cke high at SRX", ev_cke[2], 1);
    chk("R6 cke low span", low_cnt, ev_cyc[2] - ev_cyc[1]);
    chk("R2 MR2 after tXS", ev_cyc[3] - ev_cyc[2], T_XS);
    chk("R3 MR2 select", ev_ba[3], 2);
    chk("R2 MR2 data", ev_dat[3], int'(MR2V));
    chk("R2 MR3 after tMRD", ev_cyc[4] - ev_cyc[3], T_MRD);
    chk("R3 MR3 select", ev_ba[4], 3);
    chk("R2 MR0 after tMRD", ev_cyc[5] - ev_cyc[4], T_MRD);
    chk("R3 MR0 select", ev_ba[5], 0);
    chk("R5 MR0 dll reset clear", ev_dat[5], int'(MR0V & ~16'h0100));
    chk("R9 done after tMOD", done_cyc - ev_cyc[5], T_MOD);
    chk("R9 single done", n_done, 1);
    chk("R9 idle after done", int'(busy_o), 0);
  endtask

  task automatic check_enable(input int s, input int k);
    chk("R4 enable event count", n_ev, 7);
    chk("R4 SRE first", ev_cmd[0], 2);
    chk("R4 SRE timing", ev_cyc[0], s + 1);
    chk("R7 retune after tCKSRE", fr_cyc - ev_cyc[0], T_CKSRE);
    chk("R8 SRX timing", ev_cyc[1], k + T_CKSRX);
    chk("R4 SRX cmd", ev_cmd[1], 3);
    chk("R6 cke low span", low_cnt, ev_cyc[1] - ev_cyc[0]);
    chk("R4 MR1 after tXS", ev_cyc[2] - ev_cyc[1], T_XS);
    chk("R3 MR1 select", ev_ba[2], 1);
    chk("R3 MR1 dll on bit clear", ev_dat[2], int'(MR1V & ~16'h0001));
    chk("R4 MR0 after tMRD", ev_cyc[3] - ev_cyc[2], T_MRD);
    chk("R3 MR0 select", ev_ba[3], 0);
    chk("R5 MR0 dll reset set", ev_dat[3], int'(MR0V | 16'h0100));
    chk("R4 MR2 after tMOD", ev_cyc[4] - ev_cyc[3], T_MOD);
    chk("R3 MR2 select", ev_ba[4], 2);
    chk("R4 MR3 after tMRD", ev_cyc[5] - ev_cyc[4], T_MRD);
    chk("R3 MR3 select", ev_ba[5], 3);
    chk("R2 MR3 data", ev_dat[5], int'(MR3V));
    chk("R4 ZQCL after tMOD", ev_cyc[6] - ev_cyc[5], T_MOD);
    chk("R4 ZQCL cmd", ev_cmd[6], 4);
    chk("R9 done after ZQ wait", done_cyc - ev_cyc[6], zq_wait());
    chk("R9 lock time met", int'(done_cyc - ev_cyc[3] >= T_DLLK), 1);
    chk("R9 single done", n_done, 1);
  endtask

  task automatic t_reset();
    rst_n = 0; start_i = 0; dll_on_i = 0; odt_req_i = 0; clk_stable_i = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset cmd NOP", int'(cmd_o), 0);
    chk("R1 reset cke", int'(cke_o), 1);
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset freq_req", int'(freq_req_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_odt_block();
    clear_log(); rec_en = 1;
    odt_req_i = 1;
    @(negedge clk);
    chk("R10 odt passes when idle", int'(odt_o), 1);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (4) @(negedge clk);
    chk("R1 start with odt ignored busy", int'(busy_o), 0);
    chk("R1 start with odt ignored cmds", n_ev, 0);
    odt_req_i = 0;
    @(negedge clk);
  endtask

  task automatic t_disable();
    int s, k;
    clear_log(); rec_en = 1;
    run_seq(1'b0, 3, 1'b0, 1'b0, 1'b0, s, k);
    check_disable(s, k);
  endtask

  task automatic t_enable_poke();
    int s, k;
    clear_log(); rec_en = 1;
    run_seq(1'b1, 5, 1'b0, 1'b1, 1'b0, s, k);
    check_enable(s, k);
  endtask

  task automatic t_glitch();
    int s, k;
    clear_log(); rec_en = 1;
    run_seq(1'b0, 2, 1'b1, 1'b0, 1'b0, s, k);
    check_disable(s, k);
  endtask

  task automatic t_start_on_done();
    int s, k, n0;
    clear_log(); rec_en = 1;
    run_seq(1'b1, 1, 1'b0, 1'b0, 1'b1, s, k);
    check_enable(s, k);
    n0 = n_ev;
    repeat (10) @(negedge clk);
    chk("R12 start on done ignored busy", int'(busy_o), 0);
    chk("R12 start on done no commands", n_ev, n0);
    chk("R11 idle drives NOP", int'(cmd_o), 0);
  endtask

  initial begin
    t_reset();
    t_odt_block();
    t_disable();
    t_enable_poke();
    t_glitch();
    t_start_on_done();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule